// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block lets synchronous logic use a 16-bit asynchronous static RAM that has per-byte lanes. On the system side a request gives an address, write data, a per-byte mask, a read/write flag and a one-cycle start strobe. The controller turns each request into a sequence of pin levels: a chip-enable pair made of one active-low and one active-high enable, output-enable, write-strobe, per-lane byte enables and the address. When the access is complete it returns a one-cycle done pulse, and for reads the captured data comes with that pulse.

Every minimum time the memory needs is a nanosecond parameter. Each one is turned into a whole number of clock cycles by rounding up against a clock-period parameter, and no count is allowed to fall below one cycle. The controller owns the tri-state data bus. It drives the bus only while the write strobe is low. After a read it waits for the memory's output drivers to switch off before it can drive the bus again. It takes a new request only when it is idle.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no request, every pin is inactive: `sram_ce1_n`=1, `sram_ce2`=0, `sram_oe_n`=1, `sram_we_n`=1, every `sram_be_n` bit is 1, and `req_done`=0.
- R2: A read keeps the chip enabled, output-enable low and the address steady for exactly RD_N = max(ceil(55/T), ceil(25/T)) cycles, where T is the clock period in ns. `req_done` rises RD_N clock edges after the edge that samples `req_start`.
- R3: Mask bit 0 selects the low lane (data bits 7:0, `sram_be_n[0]`) and mask bit 1 selects the high lane (bits 15:8, `sram_be_n[1]`). Enable bit i is 0 exactly when mask bit i is 1, for the whole access. Read lanes that are not selected return 0 on `req_rdata`.
- R4: In a write the strobe stays low for exactly WP_N = max(ceil(40/T), ceil(25/T)) cycles, and output-enable stays high for the whole write.
- R5: In a write the address, the chip-enable pair and the byte enables are held for at least ceil(45/T) cycles before the strobe rises. They stay asserted for at least one more cycle after it rises. The address does not change while the chip is enabled.
- R6: A write changes only the lanes whose mask bit is 1. A write with mask 0 changes no data.
- R7: A write keeps the chip enabled for exactly WS_N+WP_N+WH_N cycles, and this is at least ceil(55/T). Here WS_N = max(1, ceil(45/T)-WP_N) and WH_N = max(1, ceil(55/T)-WS_N-WP_N). `req_done` rises that many edges after the edge that samples `req_start`.
- R8: The controller drives the data bus with the write data only while the strobe is low, and it releases the bus at the same edge on which the strobe rises. After a read, output-enable has been high for at least ceil(20/T) cycles before the strobe falls.
- R9: A start strobe that arrives while an access is in progress is ignored: it starts no access and gives no extra done pulse.
- R10: `req_done` is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte-lane select, bit 0 = low lane |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | DATA_W | Read data, valid with req_done |
| sram_a | output | ADDR_W | Memory address |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_be_n | output | DATA_W/8 | Active-low byte enables, bit 0 = low lane |
| sram_dq | inout | DATA_W | Bidirectional data bus |

## Verification
The bench runs through all sixteen addresses of a small memory and all four lane masks. It writes and then reads back against a bench-side model whose expected contents are worked out arithmetically. This catches a swapped lane or a mask-0 write that still stores data. Monitors measure every strobe, enable and output-enable run in cycles. A rounding slip then shows up as a strobe or read window one cycle too short, or an address setup that falls below the write-end window. The bench also checks that the bus carries the write data while the strobe is low. It checks that an idle gap follows every read before the next write drives the bus, and that a start pulsed in the middle of an access adds no extra done pulse and no stray write.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD,
        PH_TURN,
        PH_WSET,
        PH_WPULSE,
        PH_WHOLD
    } phase_e;

    // Round a time in ns up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int t_ns, input int per_ns);
        int c;
        c = (t_ns + per_ns - 1) / per_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_dq_io.sv
module sram_dq_io #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              drive_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rd_o,
    inout  wire  [DATA_W-1:0] pad_io
);
    localparam int LANES = DATA_W / LANE_W;

    // One tri-state buffer per byte lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign pad_io[l*LANE_W +: LANE_W] = drive_i ? wdata_i[l*LANE_W +: LANE_W] : {LANE_W{1'bz}};
    end

    assign rd_o = pad_io;

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    parameter int RD_N   = 3,
    parameter int TA_N   = 1,
    parameter int WS_N   = 1,
    parameter int WP_N   = 2,
    parameter int WH_N   = 1,
    parameter int CNT_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       write_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic [DATA_W/LANE_W-1:0]   mask_i,
    input  logic [DATA_W-1:0]          bus_rd_i,
    output logic                       done_o,
    output logic [DATA_W-1:0]          rdata_o,
    output logic [ADDR_W-1:0]          addr_o,
    output logic                       ce1_n_o,
    output logic                       ce2_o,
    output logic                       oe_n_o,
    output logic                       we_n_o,
    output logic [DATA_W/LANE_W-1:0]   be_n_o,
    output logic                       drive_o,
    output logic [DATA_W-1:0]          wdata_o
);
    localparam int LANES = DATA_W / LANE_W;

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [LANES-1:0]    mask;
        logic [DATA_W-1:0]   rdata;
        logic                done;
        logic                ce1_n;
        logic                ce2;
        logic                oe_n;
        logic                we_n;
        logic [LANES-1:0]    be_n;
        logic                drive;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        ph:    PH_IDLE,
        cnt:   '0,
        addr:  '0,
        wdata: '0,
        mask:  '0,
        rdata: '0,
        done:  1'b0,
        ce1_n: 1'b1,
        ce2:   1'b0,
        oe_n:  1'b1,
        we_n:  1'b1,
        be_n:  '1,
        drive: 1'b0
    };

    seq_t s_d, s_q;
    logic busy_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.addr  = addr_i;
                    s_d.wdata = wdata_i;
                    s_d.mask  = mask_i;
                    if (write_i) begin
                        s_d.ph  = PH_WSET;
                        s_d.cnt = CNT_W'(WS_N - 1);
                    end else begin
                        s_d.ph  = PH_RD;
                        s_d.cnt = CNT_W'(RD_N - 1);
                    end
                end
            end
            PH_RD: begin
                if (s_q.cnt == '0) begin
                    for (int l = 0; l < LANES; l++) begin
                        s_d.rdata[l*LANE_W +: LANE_W] =
                            s_q.mask[l] ? bus_rd_i[l*LANE_W +: LANE_W] : '0;
                    end
                    s_d.done = 1'b1;
                    s_d.ph   = PH_TURN;
                    s_d.cnt  = CNT_W'(TA_N - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_TURN: begin
                if (s_q.cnt == '0) s_d.ph = PH_IDLE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            PH_WSET: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_WPULSE;
                    s_d.cnt = CNT_W'(WP_N - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_WPULSE: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_WHOLD;
                    s_d.cnt = CNT_W'(WH_N - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_WHOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d = SEQ_RST;
        endcase

        // Registered pin levels follow from the next phase.
        busy_d    = (s_d.ph == PH_RD) || (s_d.ph == PH_WSET) ||
                    (s_d.ph == PH_WPULSE) || (s_d.ph == PH_WHOLD);
        s_d.ce1_n = ~busy_d;
        s_d.ce2   = busy_d;
        s_d.oe_n  = (s_d.ph != PH_RD);
        s_d.we_n  = (s_d.ph != PH_WPULSE);
        s_d.be_n  = busy_d ? ~s_d.mask : '1;
        s_d.drive = (s_d.ph == PH_WPULSE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign done_o  = s_q.done;
    assign rdata_o = s_q.rdata;
    assign addr_o  = s_q.addr;
    assign ce1_n_o = s_q.ce1_n;
    assign ce2_o   = s_q.ce2;
    assign oe_n_o  = s_q.oe_n;
    assign we_n_o  = s_q.we_n;
    assign be_n_o  = s_q.be_n;
    assign drive_o = s_q.drive;
    assign wdata_o = s_q.wdata;

    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.we_n |-> s_q.oe_n); // R4
    AST_WE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.we_n |-> (!s_q.ce1_n && s_q.ce2)); // R5
    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ce1_n && !$past(s_q.ce1_n)) |-> $stable(s_q.addr)); // R5
    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.we_n) |-> (!s_q.ce1_n && s_q.ce2)); // R5
    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.we_n) |-> !s_q.drive); // R8
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.drive |-> (s_q.oe_n && !s_q.we_n)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_IDLE && start_i) |=> $stable(s_q.addr)); // R9

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int LANE_W    = 8,
    parameter int CLK_NS    = 20,
    parameter int RD_CYC_NS = 55,
    parameter int ADDR_ACC_NS = 55,
    parameter int OE_ACC_NS = 25,
    parameter int BE_ACC_NS = 55,
    parameter int BUS_OFF_NS = 20,
    parameter int WR_CYC_NS = 55,
    parameter int WE_PW_NS  = 40,
    parameter int WR_SETUP_NS = 45,
    parameter int DATA_SU_NS = 25,
    parameter int ADDR_HOLD_NS = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_start,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic [DATA_W/LANE_W-1:0]   req_mask,
    output logic                       req_done,
    output logic [DATA_W-1:0]          req_rdata,
    output logic [ADDR_W-1:0]          sram_a,
    output logic                       sram_ce1_n,
    output logic                       sram_ce2,
    output logic                       sram_oe_n,
    output logic                       sram_we_n,
    output logic [DATA_W/LANE_W-1:0]   sram_be_n,
    inout  wire  [DATA_W-1:0]          sram_dq
);
    localparam int RD_N = imax(imax(ns_to_cyc(RD_CYC_NS, CLK_NS), ns_to_cyc(ADDR_ACC_NS, CLK_NS)),
                               imax(ns_to_cyc(OE_ACC_NS, CLK_NS), ns_to_cyc(BE_ACC_NS, CLK_NS)));
    localparam int TA_N = ns_to_cyc(BUS_OFF_NS, CLK_NS);
    localparam int WP_N = imax(ns_to_cyc(WE_PW_NS, CLK_NS), ns_to_cyc(DATA_SU_NS, CLK_NS));
    localparam int WS_N = imax(1, ns_to_cyc(WR_SETUP_NS, CLK_NS) - WP_N);
    localparam int WH_N = imax(ns_to_cyc(ADDR_HOLD_NS, CLK_NS), ns_to_cyc(WR_CYC_NS, CLK_NS) - WS_N - WP_N);
    localparam int MAX_N = imax(imax(RD_N, TA_N), imax(WP_N, imax(WS_N, WH_N)));
    localparam int CNT_W = imax(1, $clog2(MAX_N + 1));

    logic              drive;
    logic [DATA_W-1:0] wdata_pad;
    logic [DATA_W-1:0] bus_rd;

    sram_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W),
        .RD_N(RD_N), .TA_N(TA_N), .WS_N(WS_N), .WP_N(WP_N), .WH_N(WH_N),
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (req_start),
        .write_i (req_write),
        .addr_i  (req_addr),
        .wdata_i (req_wdata),
        .mask_i  (req_mask),
        .bus_rd_i(bus_rd),
        .done_o  (req_done),
        .rdata_o (req_rdata),
        .addr_o  (sram_a),
        .ce1_n_o (sram_ce1_n),
        .ce2_o   (sram_ce2),
        .oe_n_o  (sram_oe_n),
        .we_n_o  (sram_we_n),
        .be_n_o  (sram_be_n),
        .drive_o (drive),
        .wdata_o (wdata_pad)
    );

    sram_dq_io #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_io (
        .drive_i(drive),
        .wdata_i(wdata_pad),
        .rd_o   (bus_rd),
        .pad_io (sram_dq)
    );

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

    localparam int AW = 4;
    localparam int PER = 20;

    function automatic int cdiv(input int t);
        int c;
        c = (t + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD = mx(cdiv(55), cdiv(25));
    localparam int E_TA = cdiv(20);
    localparam int E_WP = mx(cdiv(40), cdiv(25));
    localparam int E_WS = mx(1, cdiv(45) - E_WP);
    localparam int E_WH = mx(1, cdiv(55) - E_WS - E_WP);
    localparam int E_AW = cdiv(45);
    localparam int E_WC = cdiv(55);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          req_done;
    logic [15:0]   req_rdata;
    logic [AW-1:0] sram_a;
    logic          sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n;
    logic [1:0]    sram_be_n;
    wire  [15:0]   sram_dq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] mem_m [16];
    logic [15:0] exp_m [16];
    logic [15:0] cur_wdata = '0;
    logic [1:0]  cur_mask = '0;
    int          done_cnt = 0;

    always #(PER/2) clk = ~clk;

    sram_async_ctrl #(.ADDR_W(AW), .CLK_NS(PER)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_start(req_start), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask),
        .req_done(req_done), .req_rdata(req_rdata),
        .sram_a(sram_a), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_be_n(sram_be_n),
        .sram_dq(sram_dq)
    );

    // Memory model: drives enabled lanes during a read.
    wire rd_act = !sram_ce1_n && sram_ce2 && !sram_oe_n && sram_we_n;
    assign sram_dq[7:0]  = (rd_act && !sram_be_n[0]) ? mem_m[sram_a][7:0]  : 8'hzz;
    assign sram_dq[15:8] = (rd_act && !sram_be_n[1]) ? mem_m[sram_a][15:8] : 8'hzz;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pin monitors, sampled mid-cycle.
    int  we_run = 0, oe_run = 0, ce_run = 0, oe_gap = 1000;
    bit  ce_wr = 0, prev_we = 1, prev_done = 0;
    logic [AW-1:0] ce_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit ce_on = !sram_ce1_n && sram_ce2;
            automatic logic [15:0] lm = {{8{cur_mask[1]}}, {8{cur_mask[0]}}};
            if (!sram_we_n && ce_on) begin
                if (!sram_be_n[0]) mem_m[sram_a][7:0]  = sram_dq[7:0];
                if (!sram_be_n[1]) mem_m[sram_a][15:8] = sram_dq[15:8];
            end
            if (!sram_we_n) begin
                if (prev_we) chk(oe_gap - 1 >= E_TA, "R8 turnaround", oe_gap - 1, E_TA);
                we_run++;
                chk(sram_oe_n == 1'b1, "R4 oe high in write", int'(sram_oe_n), 1);
                chk((sram_dq & lm) == (cur_wdata & lm), "R8 bus data", int'(sram_dq & lm), int'(cur_wdata & lm));
            end else if (we_run > 0) begin
                chk(we_run == E_WP, "R4 strobe width", we_run, E_WP);
                chk(ce_run >= E_AW, "R5 setup to write end", ce_run, E_AW);
                chk(ce_on, "R5 hold after write end", int'(ce_on), 1);
                we_run = 0;
            end
            if (!sram_oe_n) begin
                oe_run++;
                oe_gap = 0;
            end else begin
                if (oe_run > 0) chk(oe_run == E_RD, "R2 oe window", oe_run, E_RD);
                oe_run = 0;
                if (oe_gap < 1000) oe_gap++;
            end
            if (ce_on) begin
                if (ce_run == 0) ce_addr = sram_a;
                else chk(sram_a == ce_addr, "R5 address steady", int'(sram_a), int'(ce_addr));
                chk(sram_be_n == ~cur_mask, "R3 byte enables", int'(sram_be_n), int'(~cur_mask));
                ce_run++;
                if (!sram_we_n) ce_wr = 1;
            end else if (ce_run > 0) begin
                if (ce_wr) chk(ce_run == E_WS + E_WP + E_WH && ce_run >= E_WC, "R7 write window",
                               ce_run, E_WS + E_WP + E_WH);
                else chk(ce_run == E_RD, "R2 read window", ce_run, E_RD);
                ce_run = 0;
                ce_wr = 0;
            end
            if (req_done) begin
                done_cnt++;
                chk(!prev_done, "R10 one-cycle done", 1, 0);
            end
            prev_we = sram_we_n;
            prev_done = req_done;
        end
    end

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                         input logic [1:0] m, input bit poke, output logic [15:0] rd, output int lat);
        @(negedge clk);
        req_start = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        cur_wdata = d; cur_mask = m;
        @(negedge clk);
        req_start = 0;
        lat = 0;
        if (poke) begin
            req_start = 1; req_write = !wr; req_addr = a ^ 4'hF; req_wdata = ~d; req_mask = 2'b11;
        end
        while (!req_done && lat < 100) begin
            @(negedge clk);
            req_start = 0;
            lat++;
        end
        rd = req_rdata;
        if (wr) begin
            if (m[0]) exp_m[a][7:0]  = d[7:0];
            if (m[1]) exp_m[a][15:8] = d[15:8];
        end
        repeat (E_TA + 1) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem_m[i] = 16'hA500 ^ (16'(i) * 16'h0111);
            exp_m[i] = mem_m[i];
        end
        repeat (3) @(negedge clk);
        // R1 reset state during reset
        chk(sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n && sram_be_n == 2'b11 && !req_done,
            "R1 reset pins", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_be_n}, 6'b101111);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n && sram_be_n == 2'b11 && !req_done,
            "R1 idle pins", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_be_n}, 6'b101111);

        begin
            logic [15:0] rd;
            int lat;
            int dc;
            // Sweep: every address and every mask, write then read back.
            for (int a = 0; a < 16; a++) begin
                for (int m = 0; m < 4; m++) begin
                    automatic logic [15:0] d = 16'(a * 16'h1357 + m * 16'h2468 + 16'h0F0F);
                    do_op(1, AW'(a), d, 2'(m), 0, rd, lat);
                    chk(lat == E_WS + E_WP + E_WH, "R7 write latency", lat, E_WS + E_WP + E_WH);
                    do_op(0, AW'(a), 16'h0, 2'b11, 0, rd, lat);
                    chk(lat == E_RD, "R2 read latency", lat, E_RD);
                    chk(rd == exp_m[a], "R6 readback", int'(rd), int'(exp_m[a]));
                    do_op(0, AW'(a), 16'h0, 2'(m), 0, rd, lat);
                    chk(rd == (exp_m[a] & {{8{m[1]}}, {8{m[0]}}}), "R3 lane read",
                        int'(rd), int'(exp_m[a] & {{8{m[1]}}, {8{m[0]}}}));
                end
            end
            // R9: start pulsed during an access is ignored.
            dc = done_cnt;
            do_op(1, 4'h3, 16'hBEEF, 2'b11, 1, rd, lat);
            repeat (10) @(negedge clk);
            chk(done_cnt - dc == 1, "R9 single done on poke write", done_cnt - dc, 1);
            do_op(0, 4'hC, 16'h0, 2'b11, 0, rd, lat);
            chk(rd == exp_m[12], "R9 no stray write", int'(rd), int'(exp_m[12]));
            dc = done_cnt;
            do_op(0, 4'h3, 16'h1234, 2'b11, 1, rd, lat);
            repeat (10) @(negedge clk);
            chk(done_cnt - dc == 1, "R9 single done on poke read", done_cnt - dc, 1);
            chk(rd == 16'hBEEF, "R6 poke write data", int'(rd), 16'hBEEF);
            do_op(0, 4'hC, 16'h0, 2'b11, 0, rd, lat);
            chk(rd == exp_m[12], "R9 read poke did not write", int'(rd), int'(exp_m[12]));
            chk(sram_ce1_n && sram_we_n && sram_oe_n, "R1 idle after traffic",
                {sram_ce1_n, sram_we_n, sram_oe_n}, 3'b111);
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule